// File: doc/BRIEF.md
# Prescaled Countdown Timer with Auto-Reload

A per-processor private timer that counts a 32-bit value down to zero at a rate set by an 8-bit prescaler. Software reaches it through a simple word-addressed read/write port with four registers: the reload value, the live count, the control word and a sticky expiry flag.

When the count steps from one to zero, the expiry flag is set. The counter then either refills from the reload register and keeps running, or stays at zero. A one-cycle interrupt pulse marks each moment the flag changes from clear to set. Software clears the flag by writing a one to it.

Writing the reload register also restarts the live count. Turning the timer on while the count is zero and auto-reload is selected first copies the reload value into the count.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Registers sit at byte offsets 0x0 (reload), 0x4 (count), 0x8 (control) and 0xC (status). Any other offset, including an unaligned one, reads zero and ignores writes.
- R3: In the control word, bit 0 enables counting, bit 1 selects auto-reload and bits [15:8] hold the prescale value P. All other bits read zero. While enabled with a nonzero count, the count drops by one every P+1 clock cycles. The prescaler restarts on any write to the reload or count register and while the timer is stopped.
- R4: A write to offset 0x0 sets both the reload value and the count. A write to offset 0x4 sets only the count.
- R5: On the step from a count of one, status bit 0 is set. The count then becomes the reload value if auto-reload is on, and zero otherwise.
- R6: If a control write turns bit 0 from 0 to 1 while the count is zero and the written bit 1 is set, the count is loaded from the reload register.
- R7: Writing 1 to status bit 0 clears it. An expiry in the same cycle wins, and the flag stays set.
- R8: `irq_o` is high for exactly one cycle, in the first cycle the status flag reads 1 after having been 0. An expiry while the flag is already set gives no pulse.
- R9: Reading the count returns zero while the timer is disabled, whatever the stored count.
- R10: An enabled timer whose count is zero never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current address |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
Two pairs of functions can land on the same clock edge. A write-one-to-clear of the status flag can coincide with a timer expiry: the bench times the clear so that its edge is the reload expiry edge, then requires that the flag still reads 1 and that no interrupt pulse appears. A write to the reload register can likewise hit a running count: the bench rewrites the reload value mid-count and expects the expiry exactly three cycles after that write, not at the old deadline. Every interrupt pulse is matched against a queue of predicted cycle numbers.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } pdt_reg_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RLD_BIT = 1;
  localparam int unsigned CTRL_PS_LSB  = 8;
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] limit_i,
  output logic            step_o
);
  logic [PS_W-1:0] div_q;

  assign step_o = run_i && !restart_i && (div_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (!run_i || restart_i) div_q <= '0;
    else if (step_o)              div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end

  a_r3_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i && $stable(limit_i) |-> div_q <= limit_i || $past(!run_i || restart_i) == 1'b0);
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pull_i,
  input  logic [DATA_W-1:0] reload_val_i,
  input  logic              reload_en_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;

  assign expire_o = step_i && !wr_i && (cnt_q == DATA_W'(1));
  assign count_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)          cnt_d = wdata_i;
    else if (pull_i)   cnt_d = reload_val_i;
    else if (expire_o) cnt_d = reload_en_i ? reload_val_i : '0;
    else if (step_i)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  a_r5_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && reload_en_i |=> cnt_q == $past(reload_val_i));
  a_r5_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !reload_en_i |=> cnt_q == '0);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == '0 && !wr_i && !pull_i |=> cnt_q == '0);
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] reload_o,
  output logic              en_o,
  output logic              rld_o,
  output logic [PS_W-1:0]   ps_o,
  output logic              cnt_wr_o,
  output logic              pull_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_q;
  logic              en_q, rld_q, stat_q, stat_old_q, stat_d;
  logic [PS_W-1:0]   ps_q;
  logic              mapped;
  pdt_reg_e          sel;
  logic              wr_rld, wr_cnt, wr_ctl, wr_stat;

  assign mapped  = (addr_i[ADDR_W-1:4] == '0) && (addr_i[1:0] == 2'b00);
  assign sel     = pdt_reg_e'(addr_i[3:2]);
  assign wr_rld  = we_i && mapped && (sel == REG_RELOAD);
  assign wr_cnt  = we_i && mapped && (sel == REG_COUNT);
  assign wr_ctl  = we_i && mapped && (sel == REG_CTRL);
  assign wr_stat = we_i && mapped && (sel == REG_STATUS);

  assign cnt_wr_o = wr_rld || wr_cnt;
  assign pull_o   = wr_ctl && !en_q && wdata_i[CTRL_EN_BIT] && wdata_i[CTRL_RLD_BIT]
                    && (count_i == '0);
  assign stat_d   = expire_i ? 1'b1 : ((wr_stat && wdata_i[0]) ? 1'b0 : stat_q);
  assign irq_o    = stat_q && !stat_old_q;

  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign rld_o    = rld_q;
  assign ps_o     = ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q   <= '0;
      en_q       <= 1'b0;
      rld_q      <= 1'b0;
      ps_q       <= '0;
      stat_q     <= 1'b0;
      stat_old_q <= 1'b0;
    end else begin
      if (wr_rld) reload_q <= wdata_i;
      if (wr_ctl) begin
        en_q  <= wdata_i[CTRL_EN_BIT];
        rld_q <= wdata_i[CTRL_RLD_BIT];
        ps_q  <= wdata_i[CTRL_PS_LSB +: PS_W];
      end
      stat_q     <= stat_d;
      stat_old_q <= stat_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      unique case (sel)
        REG_RELOAD: rdata_o = reload_q;
        REG_COUNT:  rdata_o = en_q ? count_i : '0;
        REG_CTRL: begin
          rdata_o[CTRL_EN_BIT]            = en_q;
          rdata_o[CTRL_RLD_BIT]           = rld_q;
          rdata_o[CTRL_PS_LSB +: PS_W]    = ps_q;
        end
        REG_STATUS: rdata_o[0] = stat_q;
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> irq_o || $past(stat_q));
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire_i));
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_val, count;
  logic              en, rld, cnt_wr, pull, step, expire, run;
  logic [PS_W-1:0]   ps;

  assign run = en && (count != '0);

  pdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .count_i  (count),
    .expire_i (expire),
    .reload_o (reload_val),
    .en_o     (en),
    .rld_o    (rld),
    .ps_o     (ps),
    .cnt_wr_o (cnt_wr),
    .pull_o   (pull),
    .rdata_o, .irq_o
  );

  pdt_prescaler #(.PS_W(PS_W)) i_presc (
    .clk_i, .rst_ni,
    .run_i     (run),
    .restart_i (cnt_wr),
    .limit_i   (ps),
    .step_o    (step)
  );

  pdt_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk_i, .rst_ni,
    .wr_i         (cnt_wr),
    .wdata_i,
    .pull_i       (pull),
    .reload_val_i (reload_val),
    .reload_en_i  (rld),
    .step_i       (step),
    .count_o      (count),
    .expire_o     (expire)
  );

  a_r9_stopped_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !step);
endmodule

// File: tb/test_prescaled_down_timer.sv
module test_prescaled_down_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          cyc = 0;
  int          n_run = 0, n_fail = 0;
  int          exp_q[$];
  string       tag_q[$];

  prescaled_down_timer i_prescaled_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 0; #1;
    check(rdata, exp, tag);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_irq(input int t, input string tag);
    exp_q.push_back(t); tag_q.push_back(tag);
  endtask

  // Monitor: every pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) check(32'd1, 32'd0, "R8 unexpected irq");
      else begin
        int e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(cyc, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ce, cw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h0, 0, "R1 reload"); rd(6'h4, 0, "R1 count");
    rd(6'h8, 0, "R1 ctrl");   rd(6'hC, 0, "R1 status");
    check(irq, 0, "R1 irq");

    // R3/R9/R5 one-shot with prescale 2
    wr(6'h0, 5);
    rd(6'h0, 5, "R4 reload stored");
    rd(6'h4, 0, "R9 disabled count reads zero");
    wr(6'h8, 32'h0201); ce = cyc;
    expect_irq(ce + 15, "R3 one-shot expiry P=2");
    rd(6'h4, 5, "R3 count at enable");
    wait_until(ce + 2); rd(6'h4, 5, "R3 no step before P+1");
    wait_until(ce + 3); rd(6'h4, 4, "R3 first step");
    wait_until(ce + 16);
    rd(6'h4, 0, "R5 one-shot stays zero"); rd(6'hC, 1, "R5 status set");

    // R7 clear
    wr(6'hC, 0); rd(6'hC, 1, "R7 write zero keeps flag");
    wr(6'hC, 1); rd(6'hC, 0, "R7 write one clears");

    // R5/R8 auto-reload, pulse only on 0->1
    wr(6'h8, 0); wr(6'h0, 4); wr(6'hC, 1);
    wr(6'h8, 32'h3); ce = cyc;
    expect_irq(ce + 4, "R5 reload first expiry");
    wait_until(ce + 4); rd(6'h4, 4, "R5 refilled from reload");
    wait_until(ce + 7); wr(6'hC, 1);
    expect_irq(ce + 12, "R8 pulse after clear");
    wait_until(ce + 13); rd(6'hC, 1, "R8 flag set again");

    // R4/R9/R6/R10
    wr(6'h8, 0); wr(6'h4, 7);
    rd(6'h4, 0, "R9 disabled with nonzero count");
    wr(6'h4, 0);
    rd(6'h0, 4, "R4 count write leaves reload");
    wr(6'h8, 32'h3);
    rd(6'h4, 4, "R6 enable pulls reload");
    wr(6'h8, 0); wr(6'h4, 0); wr(6'h8, 32'h1);
    rd(6'h4, 0, "R6 no pull without auto-reload");
    wr(6'hC, 1);
    repeat (20) @(negedge clk);
    rd(6'hC, 0, "R10 zero count never expires");

    // R3 control field layout
    wr(6'h8, 32'hFFFF_ABFC);
    rd(6'h8, 32'h0000_AB00, "R3 control readback");
    wr(6'h8, 0);

    // R2 unmapped and unaligned
    wr(6'h10, 32'h55); rd(6'h10, 0, "R2 unmapped reads zero");
    wr(6'h01, 32'h9);  rd(6'h0, 4, "R2 unaligned write ignored");

    // R4 reload write retargets running count
    wr(6'h8, 32'h1); wr(6'h0, 100); ce = cyc;
    wait_until(ce + 10); rd(6'h4, 90, "R3 P=0 steps each cycle");
    wr(6'h0, 3); cw = cyc;
    expect_irq(cw + 3, "R4 reload write restarts count");
    wait_until(cw + 4);
    rd(6'h4, 0, "R5 stop after rewrite"); rd(6'hC, 1, "R5 flag after rewrite");

    // R7 expiry and clear on the same edge
    wr(6'h8, 0); wr(6'h0, 3); wr(6'hC, 1);
    wr(6'h8, 32'h3); ce = cyc;
    expect_irq(ce + 3, "R7 first expiry");
    wait_until(ce + 4); wr(6'hC, 1);
    rd(6'hC, 1, "R7 set wins over clear");
    wait_until(ce + 8); wr(6'h8, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size(), 0, "R8 all predicted pulses seen");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule